// File: doc/BRIEF.md
# LIN Break Detector and Autobaud Byte Receiver

This block is the receive front end of a LIN slave node. It watches a single serial input line. While it is enabled and idle, it waits for the rising edge that ends a dominant wakeup pulse, and then arms itself to look for a sync break. Break length is judged in bit periods at the bit period currently in use. A low stretch that is too short is reported as a break error and the search simply continues.

Once a break has been accepted, the block times the 0x55 sync character and replaces its working bit period with the measured one. It then receives the identifier and every following byte as 8N1 characters at that corrected rate, giving one strobe per good byte. The host owns checksum checking and frame length. It sends the block back to break search with a re-arm pulse once it has seen the checksum.

Top module: `lin_autobaud_rx`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `state_o` = 0 (idle), `period_o` equal to `nominal_period_i`, and `byte_vld_o`, `brk_err_o` and `frm_err_o` all low.
- R2: In idle (`state_o` = 0), the block stays idle while `en_i` is low, whatever the line does. With `en_i` high, a rising edge on `rx_i` moves it to break search (`state_o` = 1).
- R3: In break search, a low stretch of at least 11 times `period_o` clock cycles is accepted as a break when the line next rises. The block then enters sync measurement (`state_o` = 2) without raising `brk_err_o`.
- R4: A low stretch shorter than 11 times `period_o` gives a one-cycle `brk_err_o` pulse when the line rises, and the block stays in break search. The low-time counter saturates, so a very long low is still accepted as a break.
- R5: In sync measurement, `period_o` becomes the number of clock cycles from the first to the fifth rising edge of the line, shifted right by 3. The block then enters byte reception (`state_o` = 3). `period_o` changes in no other state except reset.
- R6: In byte reception, each character is a low start bit, 8 data bits sent least significant bit first, and a high stop bit. Each bit is sampled at mid-period, counted from the falling edge of the start bit. A good character is presented on `byte_o` with a one-cycle `byte_vld_o` pulse.
- R7: A character whose stop bit samples low gives a one-cycle `frm_err_o` pulse and no `byte_vld_o`.
- R8: A `rearm_i` pulse in any non-idle state returns the block to break search (`state_o` = 1). Dropping `en_i` returns it to idle (`state_o` = 0) while keeping `period_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, asynchronous |
| en_i | input | 1 | Receiver enable |
| rearm_i | input | 1 | Host pulse: return to break search |
| nominal_period_i | input | CNT_W | Nominal bit period in clock cycles, loaded at reset |
| byte_o | output | 8 | Last received byte |
| byte_vld_o | output | 1 | One-cycle strobe for a good byte |
| brk_err_o | output | 1 | One-cycle strobe for a too-short break |
| frm_err_o | output | 1 | One-cycle strobe for a low stop bit |
| period_o | output | CNT_W | Working bit period in clock cycles |
| state_o | output | 2 | 0 idle, 1 break search, 2 sync measurement, 3 byte reception |

## Verification
The assertions assume that the bit period is at least 4 cycles. They also assume that 11 times the period, and 8 periods plus one, fit the internal counters. Finally, they assume that the host raises `rearm_i` only between characters. The stimulus uses bit periods of 16 to 24 cycles, sends each sync character at the same exact period as the bytes that follow it, and pulses re-arm only while the line is idle high. One break is held low far past counter saturation, to exercise the clamp.

// File: rtl/lin_pkg.sv
package lin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBRK  = 2'd1,
        ST_SYNC  = 2'd2,
        ST_BYTES = 2'd3
    } lin_st_e;

    localparam int BRK_BITS  = 11;
    localparam int SYNC_RISE = 5;
endpackage

// File: rtl/lin_rx_edge.sv
module lin_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_i,
    output logic rx_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], rx_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign rx_o   = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/lin_byte_rx.sv
module lin_byte_rx #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             rx_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [7:0]       data_o,
    output logic             vld_o,
    output logic             ferr_o
);
    localparam logic [3:0] LAST_IDX = 4'd9;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       idx;
        logic [7:0]       sh;
        logic [7:0]       data;
        logic             vld;
        logic             ferr;
    } brx_s;

    brx_s d, q;

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.ferr = 1'b0;
        if (!run_i) begin
            d.busy = 1'b0;
        end else if (!q.busy) begin
            if (fall_i) begin
                d.busy = 1'b1;
                d.cnt  = (period_i >> 1) - CNT_W'(1);
                d.idx  = 4'd0;
            end
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - CNT_W'(1);
        end else begin
            d.cnt = period_i - CNT_W'(1);
            d.idx = q.idx + 4'd1;
            if (q.idx == 4'd0) begin
                if (rx_i) d.busy = 1'b0;
            end else if (q.idx < LAST_IDX) begin
                d.sh = {rx_i, q.sh[7:1]};
            end else begin
                d.busy = 1'b0;
                if (rx_i) begin
                    d.vld  = 1'b1;
                    d.data = q.sh;
                end else begin
                    d.ferr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign data_o = q.data;
    assign vld_o  = q.vld;
    assign ferr_o = q.ferr;

    assert_vld_needs_run_R6: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> $past(run_i));
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(vld_o && ferr_o));
endmodule

// File: rtl/lin_autobaud_rx.sv
module lin_autobaud_rx
    import lin_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    input  logic             en_i,
    input  logic             rearm_i,
    input  logic [CNT_W-1:0] nominal_period_i,
    output logic [7:0]       byte_o,
    output logic             byte_vld_o,
    output logic             brk_err_o,
    output logic             frm_err_o,
    output logic [CNT_W-1:0] period_o,
    output logic [1:0]       state_o
);
    localparam int LOW_W = CNT_W + 4;
    localparam int MEAS_W = CNT_W + 3;
    localparam logic [LOW_W-1:0] LOW_MAX = '1;

    typedef struct packed {
        lin_st_e           st;
        logic [CNT_W-1:0]  period;
        logic [LOW_W-1:0]  lowcnt;
        logic [MEAS_W-1:0] meas;
        logic [2:0]        rises;
        logic              brk_err;
    } top_s;

    top_s d, q;
    logic rx_s, rise, fall;
    logic [LOW_W-1:0] brk_lim;
    logic [MEAS_W-1:0] meas_inc;

    lin_rx_edge #(.STAGES(2)) u_edge (
        .clk(clk), .rst(rst), .rx_i(rx_i),
        .rx_o(rx_s), .rise_o(rise), .fall_o(fall)
    );

    assign brk_lim  = LOW_W'(q.period) * LOW_W'(BRK_BITS);
    assign meas_inc = q.meas + MEAS_W'(1);

    always_comb begin
        d         = q;
        d.brk_err = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (en_i && rise) d.st = ST_WBRK;
            end
            ST_WBRK: begin
                if (fall) d.lowcnt = LOW_W'(1);
                else if (!rx_s && q.lowcnt != LOW_MAX) d.lowcnt = q.lowcnt + LOW_W'(1);
                if (rise) begin
                    if (q.lowcnt >= brk_lim) begin
                        d.st    = ST_SYNC;
                        d.rises = 3'd0;
                        d.meas  = '0;
                    end else begin
                        d.brk_err = 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (q.rises != 3'd0) d.meas = meas_inc;
                if (rise) begin
                    d.rises = q.rises + 3'd1;
                    if (q.rises == 3'd0) d.meas = '0;
                    if (q.rises == 3'(SYNC_RISE - 1)) begin
                        d.period = CNT_W'(meas_inc >> 3);
                        d.st     = ST_BYTES;
                    end
                end
            end
            default: ;
        endcase
        if (!en_i) begin
            d.st      = ST_IDLE;
            d.brk_err = 1'b0;
        end else if (rearm_i && q.st != ST_IDLE) begin
            d.st      = ST_WBRK;
            d.lowcnt  = '0;
            d.brk_err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.period <= nominal_period_i;
        end else begin
            q <= d;
        end
    end

    lin_byte_rx #(.CNT_W(CNT_W)) u_byte (
        .clk(clk), .rst(rst), .run_i(q.st == ST_BYTES),
        .rx_i(rx_s), .fall_i(fall), .period_i(q.period),
        .data_o(byte_o), .vld_o(byte_vld_o), .ferr_o(frm_err_o)
    );

    assign brk_err_o = q.brk_err;
    assign period_o  = q.period;
    assign state_o   = q.st;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (state_o == 2'd0 && period_o == $past(nominal_period_i) && !brk_err_o));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE && !en_i) |=> q.st == ST_IDLE);
    assert_brk_err_wbrk_R4: assert property (@(posedge clk) disable iff (rst)
        brk_err_o |-> q.st == ST_WBRK);
    assert_lowcnt_sat_R4: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_WBRK && q.lowcnt == LOW_MAX && !rx_s && !fall && en_i && !rearm_i)
        |=> q.lowcnt == LOW_MAX);
    assert_period_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (q.st != ST_SYNC) |=> $stable(period_o));
    assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && rearm_i && q.st != ST_IDLE) |=> q.st == ST_WBRK);
endmodule

// File: tb/sim_lin_autobaud_rx.sv
module sim_lin_autobaud_rx;
    localparam int CW = 8;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx = 1'b1, en = 1'b0, rearm = 1'b0;
    logic [CW-1:0] nom = CW'(16);
    logic [7:0] byte_o;
    logic byte_vld, brk_err, frm_err;
    logic [CW-1:0] period;
    logic [1:0] state;

    int checks = 0, fails = 0, brk_cnt = 0, frm_cnt = 0;
    logic [7:0] expq[$];

    always #10 clk = ~clk;

    lin_autobaud_rx #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .rx_i(rx), .en_i(en), .rearm_i(rearm),
        .nominal_period_i(nom), .byte_o(byte_o), .byte_vld_o(byte_vld),
        .brk_err_o(brk_err), .frm_err_o(frm_err), .period_o(period), .state_o(state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (brk_err) brk_cnt++;
            if (frm_err) frm_cnt++;
            if (byte_vld) begin
                if (expq.size() == 0) chk("R6 unexpected byte", int'(byte_o), -1);
                else chk("R6 byte value", int'(byte_o), int'(expq.pop_front()));
            end
        end
    end

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_hi, input int p, input logic expect_it);
        if (expect_it && stop_hi) expq.push_back(b);
        hold(1'b0, p);
        for (int i = 0; i < 8; i++) hold(b[i], p);
        hold(stop_hi, p);
        hold(1'b1, 2 * p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 state", int'(state), 0);
        chk("R1 period", int'(period), 16);
        chk("R1 strobes", int'({byte_vld, brk_err, frm_err}), 0);
        // R2: wakeup pulse with enable low is ignored
        hold(1'b0, 40); hold(1'b1, 10);
        chk("R2 disabled idle", int'(state), 0);
        en = 1'b1;
        hold(1'b0, 40); hold(1'b1, 10);
        chk("R2 wake to break search", int'(state), 1);
        // R3: 13-bit break at period 20 (260 cycles >= 176)
        hold(1'b0, 260); hold(1'b1, 40);
        chk("R3 break accepted", int'(state), 2);
        chk("R3 no break error", brk_cnt, 0);
        // R5: sync 0x55 at period 20
        send_byte(8'h55, 1'b1, 20, 1'b0);
        chk("R5 measured period", int'(period), 20);
        chk("R5 byte state", int'(state), 3);
        // R6: identifier and data
        send_byte(8'h3C, 1'b1, 20, 1'b1);
        send_byte(8'hA5, 1'b1, 20, 1'b1);
        send_byte(8'h00, 1'b1, 20, 1'b1);
        send_byte(8'hFF, 1'b1, 20, 1'b1);
        chk("R6 all bytes seen", expq.size(), 0);
        // R7: low stop bit
        send_byte(8'h81, 1'b0, 20, 1'b1);
        chk("R7 framing error", frm_cnt, 1);
        chk("R7 no byte", expq.size(), 0);
        // R8: re-arm
        rearm = 1'b1; @(negedge clk); rearm = 1'b0; @(negedge clk);
        chk("R8 rearm", int'(state), 1);
        // R4: short break 180 < 220
        hold(1'b0, 180); hold(1'b1, 20);
        chk("R4 break error pulse", brk_cnt, 1);
        chk("R4 stays searching", int'(state), 1);
        // R4: very long low saturates the counter and is accepted
        hold(1'b0, 5000); hold(1'b1, 40);
        chk("R4 saturated break", int'(state), 2);
        chk("R4 no extra error", brk_cnt, 1);
        send_byte(8'h55, 1'b1, 24, 1'b0);
        chk("R5 new period", int'(period), 24);
        send_byte(8'h5A, 1'b1, 24, 1'b1);
        chk("R6 byte at new rate", expq.size(), 0);
        en = 1'b0; @(negedge clk); @(negedge clk);
        chk("R8 disable to idle", int'(state), 0);
        chk("R8 period kept", int'(period), 24);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule